// File: doc/BRIEF.md
# Serial 1001 Pattern Detector

This block watches a serial bit stream, taking one bit on each clock edge where the valid strobe is high. It raises its detect output when the four most recent accepted bits form the pattern 1, 0, 0, 1. Bits taken while the strobe is low are ignored. The same source builds all four detector variants, selected at elaboration:

- **Output style:** a Moore output that comes from the state register alone, or a Mealy output that reacts to the current input within the cycle.
- **Matching rule:** overlapping, where the last 1 of a match may start the next match, or non-overlapping, where each accepted bit belongs to at most one match.

A third parameter sets how the state register is coded: plain binary, Gray, or one-hot. Detection behaviour does not change with this choice. Only the register width and the next-state decode depend on it.

A typical use is framing or marker spotting behind a deserialiser or a sampling stage that already runs on the block's clock. The bit data and the strobe arrive synchronous to that clock.

Top module: `bitpat_detect`

## Requirements
- R1: While `rst` is high, `hit` is 0. A reset on any edge returns the search to its empty state, so bits accepted before the reset never count towards a match.
- R2: After the accepted bits 1, 0, 0, 1, `hit` goes to 1 for that match. This holds in all four variants.
- R3: A broken prefix restarts the search at the right point. A 1 arriving after "1" or "10" counts as a new leading 1. A 0 arriving after "100" clears the search. The stream 11010001001 gives exactly one detection.
- R4: In Moore style (`MEALY`=0), `hit` rises in the cycle after the edge that accepts the final 1. It stays at 1 until the next edge that accepts a bit, and it depends only on the state register.
- R5: In Mealy style (`MEALY`=1), `hit` is 1 in the same cycle as the final 1, while `bit_vld` is high and the search holds "100". `hit` is 0 in every other case.
- R6: With `OVERLAP`=1, the final 1 of a match is reused as the first 1 of the next match. The stream 1001001 gives two detections.
- R7: With `OVERLAP`=0, a new match starts only with bits that come after the previous match. The stream 1001001 gives one detection, and the stream 10011001 gives two.
- R8: A cycle with `bit_vld` low leaves the search state unchanged, whatever `bit_in` carries. In Mealy style, `hit` is 0 in such a cycle.
- R9: `ENC` selects the state coding: 0 for binary (code = state index), 1 for Gray (index XOR index>>1), 2 for one-hot (bit number = state index). The `hit` sequence is the same for all three codings. The register always holds a legal code, and an illegal code is decoded as the empty state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | High when `bit_in` carries a bit to accept this cycle |
| hit | output | 1 | Pattern detect |

## Verification
The assertions assume that `bit_in` and `bit_vld` are synchronous to `clk` and settled before each rising edge. They also assume that `rst` is held high from time zero until the first edge, so the state register starts from a known code. The bench changes every input only on the falling edge and keeps reset high over the first edges of each scenario. It then compares the detect output of all twelve variant and coding combinations against a shift-history model of each matching rule.

// File: rtl/bitpat_pkg.sv
package bitpat_pkg;

  // State register coding choices
  typedef enum logic [1:0] {
    ENC_BIN    = 2'd0,
    ENC_GRAY   = 2'd1,
    ENC_ONEHOT = 2'd2
  } enc_e;

  // Search progress: how much of 1-0-0-1 has been seen
  localparam int PH_W = 3;
  typedef enum logic [PH_W-1:0] {
    PH_IDLE = 3'd0,   // nothing useful seen
    PH_1    = 3'd1,   // "1"
    PH_10   = 3'd2,   // "10"
    PH_100  = 3'd3,   // "100"
    PH_DONE = 3'd4    // full match (registered-output style only)
  } phase_e;

endpackage

// File: rtl/bitpat_step.sv
module bitpat_step
  import bitpat_pkg::*;
#(
  parameter bit MEALY   = 1'b0,
  parameter bit OVERLAP = 1'b1
) (
  input  phase_e cur,
  input  logic   bit_in,
  input  logic   bit_vld,
  output phase_e nxt,
  output logic   match
);

  always_comb begin
    nxt   = cur;
    match = 1'b0;
    if (bit_vld) begin
      unique case (cur)
        PH_IDLE: nxt = bit_in ? PH_1 : PH_IDLE;
        PH_1:    nxt = bit_in ? PH_1 : PH_10;
        PH_10:   nxt = bit_in ? PH_1 : PH_100;
        PH_100: begin
          if (bit_in) begin
            match = 1'b1;
            if (MEALY) nxt = OVERLAP ? PH_1 : PH_IDLE;
            else       nxt = PH_DONE;
          end else begin
            nxt = PH_IDLE;
          end
        end
        PH_DONE: begin
          if (bit_in) nxt = PH_1;
          else        nxt = OVERLAP ? PH_10 : PH_IDLE;
        end
        default: nxt = PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bitpat_statereg.sv
module bitpat_statereg
  import bitpat_pkg::*;
#(
  parameter enc_e ENC = ENC_BIN,
  parameter int   NST = 5
) (
  input  logic   clk,
  input  logic   rst,
  input  phase_e nxt,
  output phase_e cur
);

  localparam int CW = (ENC == ENC_ONEHOT) ? NST : $clog2(NST);
  localparam logic [CW-1:0] RST_CODE = (ENC == ENC_ONEHOT) ? CW'(1) : '0;

  logic [CW-1:0]   code_q;
  logic [CW-1:0]   code_d;
  logic [PH_W-1:0] nv;

  assign nv = nxt;

  always_ff @(posedge clk) begin
    if (rst) code_q <= RST_CODE;
    else     code_q <= code_d;
  end

  generate
    if (ENC == ENC_ONEHOT) begin : g_onehot
      logic [PH_W-1:0] pos;
      int              ones;

      always_comb begin
        code_d = '0;
        for (int i = 0; i < CW; i++) code_d[i] = (int'(nv) == i);
      end

      always_comb begin
        pos  = '0;
        ones = 0;
        for (int i = 0; i < CW; i++) begin
          if (code_q[i]) begin
            pos  = PH_W'(i);
            ones = ones + 1;
          end
        end
        cur = (ones == 1) ? phase_e'(pos) : PH_IDLE;
      end

      // R9
      onehot_legal_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot(code_q));

    end else begin : g_dense
      logic [CW-1:0] idx;

      if (ENC == ENC_GRAY) begin : g_gray
        always_comb code_d = CW'(nv ^ (nv >> 1));
        always_comb begin
          idx[CW-1] = code_q[CW-1];
          for (int i = CW - 2; i >= 0; i--) idx[i] = idx[i+1] ^ code_q[i];
        end
      end else begin : g_bin
        always_comb code_d = CW'(nv);
        always_comb idx = code_q;
      end

      always_comb cur = (int'(idx) < NST) ? phase_e'(PH_W'(idx)) : PH_IDLE;

      // R9
      code_legal_chk: assert property (@(posedge clk) disable iff (rst)
        int'(idx) < NST);
    end
  endgenerate

endmodule

// File: rtl/bitpat_emit.sv
module bitpat_emit
  import bitpat_pkg::*;
#(
  parameter bit MEALY = 1'b0
) (
  input  logic   rst,
  input  phase_e cur,
  input  logic   match,
  output logic   hit
);

  generate
    if (MEALY) begin : g_mealy
      assign hit = match & ~rst;
    end else begin : g_moore
      logic unused_match;
      assign unused_match = match;
      assign hit = (cur == PH_DONE) & ~rst;
    end
  endgenerate

endmodule

// File: rtl/bitpat_detect.sv
module bitpat_detect
  import bitpat_pkg::*;
#(
  parameter bit   MEALY   = 1'b0,
  parameter bit   OVERLAP = 1'b1,
  parameter enc_e ENC     = ENC_BIN
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_vld,
  output logic hit
);

  localparam int NST = MEALY ? 4 : 5;

  phase_e cur;
  phase_e nxt;
  logic   match;

  bitpat_step #(.MEALY(MEALY), .OVERLAP(OVERLAP)) u_step (
    .cur     (cur),
    .bit_in  (bit_in),
    .bit_vld (bit_vld),
    .nxt     (nxt),
    .match   (match)
  );

  bitpat_statereg #(.ENC(ENC), .NST(NST)) u_state (
    .clk (clk),
    .rst (rst),
    .nxt (nxt),
    .cur (cur)
  );

  bitpat_emit #(.MEALY(MEALY)) u_emit (
    .rst   (rst),
    .cur   (cur),
    .match (match),
    .hit   (hit)
  );

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(cur));

  generate
    if (MEALY) begin : g_mealy_chk
      // R5
      mealy_fire_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> (bit_vld && bit_in && cur == PH_100));
      // R6 R7
      mealy_resume_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> (cur == (OVERLAP ? PH_1 : PH_IDLE)));
    end else begin : g_moore_chk
      // R4
      moore_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hit) |-> $past(bit_vld && bit_in && cur == PH_100));
      // R6 R7
      moore_resume_chk: assert property (@(posedge clk) disable iff (rst)
        (cur == PH_DONE && bit_vld && !bit_in) |=> (cur == (OVERLAP ? PH_10 : PH_IDLE)));
    end
  endgenerate

endmodule

// File: tb/tb_bitpat_detect.sv
`timescale 1ns/1ps
module tb_bitpat_detect;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_in = 1'b0;
  logic        bit_vld = 1'b0;
  logic [11:0] hits;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  // Reference model state per mode: index m, bit0 = Mealy, bit1 = overlap
  logic [2:0] hist [4];
  int         cnt  [4];
  bit         flag [4];
  int         nhit [4];
  bit         prev_v;

  always #4 clk = ~clk;

  for (genvar m = 0; m < 4; m++) begin : g_mode
    for (genvar e = 0; e < 3; e++) begin : g_enc
      bitpat_detect #(
        .MEALY   (m % 2 == 1),
        .OVERLAP (m / 2 == 1),
        .ENC     (bitpat_pkg::enc_e'(e))
      ) dut (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (bit_in),
        .bit_vld (bit_vld),
        .hit     (hits[m*3+e])
      );
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit r, input bit b, input bit v, input string req);
    @(negedge clk);
    rst = r; bit_in = b; bit_vld = v;
    #1;
    for (int m = 0; m < 4; m++) begin
      bit mealy;
      bit ov;
      bit mt;
      bit ex;
      mealy = (m % 2 == 1);
      ov    = (m / 2 == 1);
      mt    = !r && v && b && cnt[m] >= 3 && hist[m] == 3'b100;
      ex    = r ? 1'b0 : (mealy ? mt : flag[m]);
      for (int e = 0; e < 3; e++) begin
        chk(hits[m*3+e] == ex, $sformatf("%s mode%0d enc%0d", req, m, e), int'(hits[m*3+e]), int'(ex));
        if (e > 0)
          chk(hits[m*3+e] == hits[m*3], $sformatf("R9 coding match mode%0d enc%0d", m, e),
              int'(hits[m*3+e]), int'(hits[m*3]));
      end
      if (mealy ? hits[m*3] : (hits[m*3] && prev_v)) nhit[m]++;
      if (r) begin
        hist[m] = '0; cnt[m] = 0; flag[m] = 1'b0;
      end else if (v) begin
        flag[m] = mt;
        if (mt && !ov) begin
          hist[m] = '0; cnt[m] = 0;
        end else begin
          hist[m] = {hist[m][1:0], b};
          cnt[m]  = (cnt[m] < 3) ? cnt[m] + 1 : 3;
        end
      end
    end
    prev_v = v && !r;
  endtask

  task automatic restart(input string req);
    step(1'b1, 1'b1, 1'b1, req);
    step(1'b1, 1'b0, 1'b0, req);
    for (int m = 0; m < 4; m++) nhit[m] = 0;
  endtask

  task automatic send(input logic [15:0] pat, input int len, input string req);
    for (int i = len - 1; i >= 0; i--) step(1'b0, pat[i], 1'b1, req);
    step(1'b0, 1'b0, 1'b0, req);  // let a registered detect appear
  endtask

  task automatic count_is(input int exp_ov, input int exp_nov, input string req);
    for (int m = 0; m < 4; m++) begin
      int ex;
      ex = (m / 2 == 1) ? exp_ov : exp_nov;
      chk(nhit[m] == ex, $sformatf("%s detect count mode%0d", req, m), nhit[m], ex);
    end
  endtask

  // R1: reset state and reset in the middle of a pattern
  task automatic t_reset;
    restart("R1");
    send(16'b100, 3, "R1");
    step(1'b1, 1'b1, 1'b1, "R1");
    step(1'b0, 1'b1, 1'b1, "R1");
    step(1'b0, 1'b0, 1'b0, "R1");
    count_is(0, 0, "R1");
  endtask

  // R2: single clean match
  task automatic t_single;
    restart("R2");
    send(16'b1001, 4, "R2");
    count_is(1, 1, "R2");
  endtask

  // R3: broken prefixes restart correctly
  task automatic t_fallback;
    restart("R3");
    send(16'b110_1000_1001, 11, "R3");
    count_is(1, 1, "R3");
  endtask

  // R4: registered detect holds across idle cycles, drops on next accepted bit
  task automatic t_moore_hold;
    restart("R4");
    for (int i = 3; i >= 0; i--) step(1'b0, i[0] ^ i[1] ? 1'b0 : 1'b1, 1'b1, "R4");
    step(1'b0, 1'b1, 1'b0, "R4");
    step(1'b0, 1'b0, 1'b0, "R4");
    step(1'b0, 1'b1, 1'b0, "R4");
    step(1'b0, 1'b0, 1'b1, "R4");
    step(1'b0, 1'b0, 1'b0, "R4");
  endtask

  // R5 R8: combinational detect only with a valid final 1
  task automatic t_mealy_idle;
    restart("R5");
    send(16'b100, 3, "R5");
    step(1'b0, 1'b1, 1'b0, "R8");
    step(1'b0, 1'b1, 1'b0, "R8");
    step(1'b0, 1'b1, 1'b1, "R5");
    step(1'b0, 1'b0, 1'b0, "R5");
    count_is(1, 1, "R5");
  endtask

  // R8: pattern spread over idle cycles carrying junk
  task automatic t_gaps;
    restart("R8");
    step(1'b0, 1'b1, 1'b1, "R8");
    step(1'b0, 1'b1, 1'b0, "R8");
    step(1'b0, 1'b0, 1'b1, "R8");
    step(1'b0, 1'b1, 1'b0, "R8");
    step(1'b0, 1'b1, 1'b0, "R8");
    step(1'b0, 1'b0, 1'b1, "R8");
    step(1'b0, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b1, 1'b1, "R8");
    step(1'b0, 1'b0, 1'b0, "R8");
    count_is(1, 1, "R8");
  endtask

  // R6 R7: shared final 1
  task automatic t_overlap;
    restart("R6");
    send(16'b1001001, 7, "R6");
    count_is(2, 1, "R6 R7");
  endtask

  // R7: back-to-back matches with no shared bits
  task automatic t_back_to_back;
    restart("R7");
    send(16'b1001_1001, 8, "R7");
    count_is(2, 2, "R7");
  endtask

  // R9: long pseudo-random stream with sparse idle cycles
  task automatic t_random;
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    restart("R9");
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(1'b0, lfsr[0], lfsr[3] | lfsr[7], "R9");
    end
  endtask

  initial begin
    for (int m = 0; m < 4; m++) begin
      hist[m] = '0; cnt[m] = 0; flag[m] = 1'b0; nhit[m] = 0;
    end
    prev_v = 1'b0;
    t_reset();
    t_single();
    t_fallback();
    t_moore_hold();
    t_mealy_idle();
    t_gaps();
    t_overlap();
    t_back_to_back();
    t_random();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule